// File: doc/BRIEF.md
# Power Management Event Router

This block takes single-cycle power-management event pulses from a root port and sends each one along two paths that are enabled separately. The system-control path records the event in a sticky status bit and holds a level request for as long as that bit and its enable are both set. The system-management path records the event in its own sticky status bit and emits a one-cycle request pulse. A single event may drive both paths in the same cycle.

Two 32-bit registers reach both paths through a simple register port. Write data and address are sampled at the clock edge, and read data is a combinational function of the address. The control register holds the two enables. The status register holds the two sticky bits, and software clears them by writing 1 to them.

Top module: `pm_event_router`

## Requirements
- R1: After reset both registers read zero, `sci_req` is low and `smi_pulse` is low.
- R2: The control register at byte address 0xD8 keeps written bit 0 (system-management enable) and bit 31 (system-control enable). All other bits read as zero.
- R3: An event that is sampled while the system-control enable is set sets status bit 31 (byte address 0xDC) from the next cycle on. An event sampled while that enable is clear leaves bit 31 unchanged. The enable used is the value the register holds before any write in the same cycle.
- R4: An event that is sampled while the system-management enable is set sets status bit 0 and drives `smi_pulse` high for exactly the following cycle. With that enable clear, the event leaves bit 0 and `smi_pulse` unchanged.
- R5: The two paths are independent. With both enables set, one event sets both status bits, and `sci_req` and `smi_pulse` are high in the same cycle.
- R6: `sci_req` is high exactly when status bit 31 and control bit 31 are both 1. Clearing the enable drops the request but leaves the status bit set.
- R7: Writing 1 to a status bit clears it from the next cycle on. Writing 0 to a status bit leaves it unchanged.
- R8: When a clearing write and a setting event reach the same status bit in the same cycle, the bit stays set.
- R9: A write to any address other than 0xD8 or 0xDC changes neither register, and a read of such an address returns zero.
- R10: Events sampled on consecutive cycles with the system-management enable set give `smi_pulse` high on the same number of consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| pm_evt | input | 1 | One-cycle power-management event pulse |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sci_req | output | 1 | Level system-control interrupt request |
| smi_pulse | output | 1 | One-cycle system-management interrupt request |

## Verification
The assertions check on every cycle that each status bit holds through a clearing write when an event arrives together with it, that a clear with no competing set takes effect, and that an enabled event is always followed by an SMI pulse. They also check that a pulse never appears without a preceding event and that the control register is untouched by writes to other addresses. Only the bench scenarios can show the register layout as software sees it: which bits are kept, the zero reads of unmapped addresses, and the full outcome of every combination of enables, pre-set status, clearing mask and event. The bench compares each of those outcomes with a value it computes itself.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int DW      = 32;
  localparam int NSRC    = 2;
  localparam int IDX_SMI = 0;
  localparam int IDX_SCI = 1;
  localparam int SMI_BIT = 0;
  localparam int SCI_BIT = 31;

  // Next value of a sticky bit: a set wins over a clear in the same cycle.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Place the per-source bits at their register positions.
  function automatic logic [DW-1:0] place_bits(input logic [NSRC-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[SMI_BIT] = v[IDX_SMI];
    r[SCI_BIT] = v[IDX_SCI];
    return r;
  endfunction

  // Pick the per-source bits out of a register-wide word.
  function automatic logic [NSRC-1:0] pick_bits(input logic [DW-1:0] w);
    logic [NSRC-1:0] r;
    r[IDX_SMI] = w[SMI_BIT];
    r[IDX_SCI] = w[SCI_BIT];
    return r;
  endfunction
endpackage

// File: rtl/pmr_ctrl_reg.sv
module pmr_ctrl_reg
  import pmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [DW-1:0]   wdata,
  output logic [NSRC-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= '0;
    else if (we) en <= pick_bits(wdata);
  end

  // R2: without a write the enables do not move
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en));
endmodule

// File: rtl/pmr_sticky_bit.sv
module pmr_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= pmr_pkg::sticky_next(q, set, clr);
  end

  // R8: a set always lands, even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R7: a clear with no competing set takes effect
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  // R7: without a clear the bit is sticky
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);
endmodule

// File: rtl/pm_event_router.sv
module pm_event_router
  import pmr_pkg::*;
#(
  parameter int          AW        = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'hD8,
  parameter logic [AW-1:0] STS_ADDR  = 8'hDC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pm_evt,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sci_req,
  output logic          smi_pulse
);
  // Named internal events for the assertions
  logic            ctrl_wr, sts_wr;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] sts;
  logic [NSRC-1:0] sts_set;
  logic [NSRC-1:0] sts_clr;
  logic            smi_q;

  assign ctrl_wr = reg_wr && (reg_addr == CTRL_ADDR);
  assign sts_wr  = reg_wr && (reg_addr == STS_ADDR);

  pmr_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctrl_wr),
    .wdata (reg_wdata),
    .en    (en)
  );

  assign sts_set = {NSRC{pm_evt}} & en;
  assign sts_clr = sts_wr ? pick_bits(reg_wdata) : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_sts
    pmr_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (sts_set[i]),
      .clr   (sts_clr[i]),
      .q     (sts[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi_q <= 1'b0;
    else        smi_q <= sts_set[IDX_SMI];
  end

  assign smi_pulse = smi_q;
  assign sci_req   = sts[IDX_SCI] & en[IDX_SCI];

  always_comb begin
    if (reg_addr == CTRL_ADDR)     reg_rdata = place_bits(en);
    else if (reg_addr == STS_ADDR) reg_rdata = place_bits(sts);
    else                           reg_rdata = '0;
  end

  // R4: an enabled event is followed by a pulse and a set status bit
  p_smi_on_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_evt && en[IDX_SMI]) |=> (smi_pulse && sts[IDX_SMI]));
  // R4: no pulse without an event one cycle earlier
  p_smi_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_pulse) |-> $past(pm_evt));
  // R5: both paths fire together on one event
  p_both_paths_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_evt && (&en)) |=> (smi_pulse && sci_req));
  // R6: request persists while status and enable are left alone
  p_sci_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_req && !sts_clr[IDX_SCI] && !ctrl_wr) |=> sci_req);
  // R9: writes elsewhere leave the enables alone
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !ctrl_wr) |=> $stable(en));
endmodule

// File: tb/sim_pm_event_router.sv
module sim_pm_event_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pm_evt = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        sci_req, smi_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [7:0] A_CTRL = 8'hD8;
  localparam logic [7:0] A_STS  = 8'hDC;

  always #5 clk = ~clk;

  pm_event_router u0 (
    .clk(clk), .rst_n(rst_n), .pm_evt(pm_evt), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sci_req(sci_req), .smi_pulse(smi_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive inputs at a falling edge, return at the next falling edge
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic ev);
    reg_wr = wr; reg_addr = a; reg_wdata = d; pm_evt = ev;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 32'h0, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_wr = 1'b0; pm_evt = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
  endtask

  function automatic logic [31:0] word(input logic hi, input logic lo);
    return {hi, 30'b0, lo};
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STS, v);  chk("R1 sts", v, 0);
    chk("R1 sci_req", {31'b0, sci_req}, 0);
    chk("R1 smi_pulse", {31'b0, smi_pulse}, 0);
    rst_n = 1'b1;
    idle();

    // R2 writable bits
    step(1'b1, A_CTRL, 32'hFFFF_FFFF, 1'b0);
    rd(A_CTRL, v); chk("R2 ctrl all ones", v, 32'h8000_0001);
    step(1'b1, A_CTRL, 32'h7FFF_FFFE, 1'b0);
    rd(A_CTRL, v); chk("R2 ctrl reserved", v, 0);

    // Sweep: enables x clear mask x event, status pre-set
    for (int en = 0; en < 4; en++) begin
      for (int cm = 0; cm < 4; cm++) begin
        for (int ev = 0; ev < 2; ev++) begin
          logic e_smi, e_sci, c_smi, c_sci, x_smi, x_sci;
          e_smi = en[0]; e_sci = en[1]; c_smi = cm[0]; c_sci = cm[1];
          step(1'b1, A_CTRL, 32'h8000_0001, 1'b0);
          step(1'b0, 8'h00, 32'h0, 1'b1);
          idle();
          rd(A_STS, v); chk("R5 preset", v, 32'h8000_0001);
          step(1'b1, A_CTRL, word(e_sci, e_smi), 1'b0);
          idle();
          x_smi = (ev[0] & e_smi) | ~c_smi;
          x_sci = (ev[0] & e_sci) | ~c_sci;
          step(1'b1, A_STS, word(c_sci, c_smi), ev[0]);
          chk("R4 smi_pulse", {31'b0, smi_pulse}, {31'b0, ev[0] & e_smi});
          chk("R6 sci_req", {31'b0, sci_req}, {31'b0, x_sci & e_sci});
          rd(A_STS, v); chk("R3 R7 R8 status", v, word(x_sci, x_smi));
          idle();
          chk("R4 pulse width", {31'b0, smi_pulse}, 0);
        end
      end
    end

    // R3 / R4 from clean status with enables off
    step(1'b1, A_STS, 32'hFFFF_FFFF, 1'b0);
    step(1'b1, A_CTRL, 32'h0, 1'b0);
    step(1'b0, 8'h00, 32'h0, 1'b1);
    chk("R4 disabled no pulse", {31'b0, smi_pulse}, 0);
    rd(A_STS, v); chk("R3 disabled no status", v, 0);

    // R3 enable in the same cycle as the event uses old value
    step(1'b1, A_CTRL, 32'h8000_0001, 1'b1);
    rd(A_STS, v); chk("R3 old enable", v, 0);
    chk("R4 old enable pulse", {31'b0, smi_pulse}, 0);

    // R6 clearing enable drops request, keeps status
    step(1'b0, 8'h00, 32'h0, 1'b1);
    chk("R5 both", {30'b0, sci_req, smi_pulse}, 32'h3);
    step(1'b1, A_CTRL, 32'h0000_0001, 1'b0);
    chk("R6 dropped", {31'b0, sci_req}, 0);
    rd(A_STS, v); chk("R6 status kept", v, 32'h8000_0001);

    // R7 writing zero has no effect
    step(1'b1, A_STS, 32'h0, 1'b0);
    rd(A_STS, v); chk("R7 write zero", v, 32'h8000_0001);

    // R9 unmapped address
    step(1'b1, 8'h10, 32'hFFFF_FFFF, 1'b0);
    rd(8'h10, v); chk("R9 read zero", v, 0);
    rd(A_CTRL, v); chk("R9 ctrl kept", v, 32'h0000_0001);
    rd(A_STS, v); chk("R9 sts kept", v, 32'h8000_0001);

    // R10 back-to-back events
    step(1'b0, 8'h00, 32'h0, 1'b1);
    chk("R10 first", {31'b0, smi_pulse}, 1);
    step(1'b0, 8'h00, 32'h0, 1'b1);
    chk("R10 second", {31'b0, smi_pulse}, 1);
    step(1'b0, 8'h00, 32'h0, 1'b1);
    chk("R10 third", {31'b0, smi_pulse}, 1);
    idle();
    chk("R10 end", {31'b0, smi_pulse}, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule